// File: doc/BRIEF.md
# Cell Acknowledgement Packet Generator

Every cell slot on a switch port ends with a short acknowledgement sent back toward the cell's source on a single-bit line. This block decides which 4-bit packet that is and shifts it out. Suppose the cell was lost inside this switch element. The packet is then a locally programmed pattern, and the drop cause picks which one. The causes are collision, no live output left, and header parity error. If the cell went through, the block passes back, unchanged, the packet that the next stage or the egress device returned. If no cell arrived in the slot, a programmable idle pattern is sent.

Each switch element holds its own copy of the three cause patterns. Because of this, a source can tell from the packet both why its cell was lost and which stage dropped it. The routing decision is made elsewhere. Its outcome arrives on `drop_cause_i` together with the start-of-cell strobe.

The slot inputs carry a valid qualifier but no ready. The ack line has fixed timing, so the block never applies back-pressure. A downstream packet is accepted on any clock where `dn_vld_i` is high inside the capture window and is otherwise dropped. Configuration pins are plain.

Top module: `cell_ack_gen`

## Requirements
- R1: After reset `ack_o` is 0. The patterns reset to: idle 4'b0000, collision 4'b1001, outputs-dead 4'b1010, parity 4'b1100.
- R2: A clock edge with `cfg_we_i` high writes `cfg_wdata_i` into the pattern at `cfg_addr_i` (0 idle, 1 collision, 2 outputs-dead, 3 parity). A packet chosen on that same edge still uses the old value.
- R3: The packet goes out MSB first over four consecutive cycles. The first bit appears in the cycle after the ACK_OFS-th clock edge following the edge that sampled `soc_i`. Outside these four cycles `ack_o` is 0.
- R4: `drop_cause_i` is sampled with `soc_i` (0 none, 1 collision, 2 outputs-dead, 3 parity). A nonzero cause sends that cause's pattern.
- R5: A local drop pattern replaces any downstream packet received in the same slot.
- R6: With cause 0 and a cell present, the downstream packet is relayed unchanged. It is taken on edges 1 through ACK_OFS after the soc edge. The latest one wins, and one on edge ACK_OFS is used directly.
- R7: A slot whose `cell_vld_i` was 0 at soc sends the idle pattern, whatever the cause and downstream inputs.
- R8: A delivered cell with no downstream packet in the window sends the idle pattern.
- R9: A downstream packet presented on the soc edge, or after the send edge, has no effect on the slot.
- R10: A new `soc_i` before the send edge abandons the pending slot, and only the new slot's packet is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soc_i | input | 1 | Start-of-cell strobe, opens a slot |
| cell_vld_i | input | 1 | A cell arrived in this slot (sampled with soc_i) |
| drop_cause_i | input | 2 | Local drop cause (sampled with soc_i) |
| dn_vld_i | input | 1 | Downstream acknowledgement packet valid |
| dn_pkt_i | input | 4 | Downstream acknowledgement packet |
| cfg_we_i | input | 1 | Pattern register write strobe |
| cfg_addr_i | input | 2 | Pattern register select |
| cfg_wdata_i | input | 4 | Pattern register write data |
| ack_o | output | 1 | Serial acknowledgement line |

## Verification
Two functions can meet on a single edge, and these are the ones stressed. In the first case, a downstream packet arrives on exactly the send edge while the selector is choosing. In the second, a pattern write lands on that edge. The bench places the downstream strobe on the send edge, both with and without a local drop cause. It also places register writes on the send edge and on the edge before. Every cycle's `ack_o` is then compared with a behavioural model, which uses the pre-edge pattern, bypasses the late downstream packet, and lets a local drop win.

// File: rtl/cell_ack_gen_pkg.sv
package cell_ack_gen_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_COLL   = 2'd1,
    CAUSE_DEAD   = 2'd2,
    CAUSE_PARITY = 2'd3
  } cause_e;

  localparam int unsigned N_PAT = 4;
  localparam int unsigned PAT_IDLE = 0;
endpackage

// File: rtl/cell_ack_gen_patregs.sv
module cell_ack_gen_patregs #(
  parameter int unsigned PKT_W = 4,
  parameter logic [PKT_W-1:0] DEF_IDLE = '0,
  parameter logic [PKT_W-1:0] DEF_COLL = '0,
  parameter logic [PKT_W-1:0] DEF_DEAD = '0,
  parameter logic [PKT_W-1:0] DEF_PAR  = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we_i,
  input  logic [1:0]                            addr_i,
  input  logic [PKT_W-1:0]                      wdata_i,
  output logic [cell_ack_gen_pkg::N_PAT-1:0][PKT_W-1:0] pat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_o <= {DEF_PAR, DEF_DEAD, DEF_COLL, DEF_IDLE};
    end else if (we_i) begin
      pat_o[addr_i] <= wdata_i;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(pat_o)); // R2
endmodule

// File: rtl/cell_ack_gen_select.sv
module cell_ack_gen_select
  import cell_ack_gen_pkg::*;
#(
  parameter int unsigned PKT_W   = 4,
  parameter int unsigned ACK_OFS = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soc_i,
  input  logic                         cell_vld_i,
  input  logic [1:0]                   cause_i,
  input  logic                         dn_vld_i,
  input  logic [PKT_W-1:0]             dn_pkt_i,
  input  logic [N_PAT-1:0][PKT_W-1:0]  pat_i,
  output logic                         load_o,
  output logic [PKT_W-1:0]             pkt_o
);
  localparam int unsigned CW = $clog2(ACK_OFS + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_OFS - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic          slot_vld;
  cause_e        slot_cause;
  logic          dn_have;
  logic [PKT_W-1:0] dn_hold;
  logic          use_local, use_relay, use_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      slot_vld   <= 1'b0;
      slot_cause <= CAUSE_NONE;
      dn_have    <= 1'b0;
      dn_hold    <= '0;
    end else if (soc_i) begin
      active     <= 1'b1;
      cnt        <= '0;
      slot_vld   <= cell_vld_i;
      slot_cause <= cause_e'(cause_i);
      dn_have    <= 1'b0;
    end else if (active) begin
      if (cnt == LAST) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
      if (dn_vld_i) begin
        dn_have <= 1'b1;
        dn_hold <= dn_pkt_i;
      end
    end
  end

  assign load_o = active && !soc_i && (cnt == LAST);

  always_comb begin
    use_local = slot_vld && (slot_cause != CAUSE_NONE);
    use_relay = slot_vld && (slot_cause == CAUSE_NONE) && (dn_vld_i || dn_have);
    use_idle  = !use_local && !use_relay;
    if (use_local)      pkt_o = pat_i[slot_cause];
    else if (!use_relay) pkt_o = pat_i[PAT_IDLE];
    else if (dn_vld_i)   pkt_o = dn_pkt_i;
    else                 pkt_o = dn_hold;
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $countones({use_local, use_relay, use_idle}) == 1); // R5
  AST_DN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soc_i |=> !dn_have); // R9
  AST_SLOT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !active); // R10
endmodule

// File: rtl/cell_ack_gen_shifter.sv
module cell_ack_gen_shifter #(
  parameter int unsigned PKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PKT_W-1:0] pkt_i,
  output logic             ack_o
);
  localparam int unsigned LW = $clog2(PKT_W + 1);

  logic [PKT_W-1:0] sh;
  logic [LW-1:0]    left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load_i) begin
      sh   <= pkt_i;
      left <= LW'(PKT_W);
    end else if (left != '0) begin
      sh   <= {sh[PKT_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign ack_o = sh[PKT_W-1];

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0) |-> !ack_o); // R3
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ack_o == $past(pkt_i[PKT_W-1])); // R3
endmodule

// File: rtl/cell_ack_gen.sv
module cell_ack_gen
  import cell_ack_gen_pkg::*;
#(
  parameter int unsigned PKT_W   = 4,
  parameter int unsigned ACK_OFS = 6,
  parameter logic [PKT_W-1:0] DEF_IDLE = 4'b0000,
  parameter logic [PKT_W-1:0] DEF_COLL = 4'b1001,
  parameter logic [PKT_W-1:0] DEF_DEAD = 4'b1010,
  parameter logic [PKT_W-1:0] DEF_PAR  = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc_i,
  input  logic             cell_vld_i,
  input  logic [1:0]       drop_cause_i,
  input  logic             dn_vld_i,
  input  logic [PKT_W-1:0] dn_pkt_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [PKT_W-1:0] cfg_wdata_i,
  output logic             ack_o
);
  logic [N_PAT-1:0][PKT_W-1:0] pat;
  logic             load;
  logic [PKT_W-1:0] pkt;

  cell_ack_gen_patregs #(
    .PKT_W(PKT_W), .DEF_IDLE(DEF_IDLE), .DEF_COLL(DEF_COLL),
    .DEF_DEAD(DEF_DEAD), .DEF_PAR(DEF_PAR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .pat_o(pat)
  );

  cell_ack_gen_select #(.PKT_W(PKT_W), .ACK_OFS(ACK_OFS)) u_sel (
    .clk(clk), .rst_n(rst_n), .soc_i(soc_i), .cell_vld_i(cell_vld_i),
    .cause_i(drop_cause_i), .dn_vld_i(dn_vld_i), .dn_pkt_i(dn_pkt_i),
    .pat_i(pat), .load_o(load), .pkt_o(pkt)
  );

  cell_ack_gen_shifter #(.PKT_W(PKT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .pkt_i(pkt), .ack_o(ack_o)
  );
endmodule

// File: tb/cell_ack_gen_test.sv
module cell_ack_gen_test;
  localparam int OFS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soc = 1'b0, cvld = 1'b0, dnv = 1'b0, we = 1'b0;
  logic [1:0] cause = 2'd0, addr = 2'd0;
  logic [3:0] dnp = 4'd0, wd = 4'd0;
  logic ack;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  cell_ack_gen #(.ACK_OFS(OFS)) uut (
    .clk(clk), .rst_n(rst_n), .soc_i(soc), .cell_vld_i(cvld),
    .drop_cause_i(cause), .dn_vld_i(dnv), .dn_pkt_i(dnp),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wd), .ack_o(ack)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_pat[4];
  bit m_active, m_vld, m_have;
  int m_cnt, m_cause, m_dn, exp_bit;
  int bitq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pat = '{0, 9, 10, 12};
      m_active = 0; m_vld = 0; m_have = 0; m_cnt = 0; m_cause = 0; m_dn = 0;
      bitq.delete();
      exp_bit = 0;
    end else begin
      bit ld;
      int p;
      ld = m_active && !soc && (m_cnt == OFS - 1);
      if (ld) begin
        if (!m_vld) p = m_pat[0];
        else if (m_cause != 0) p = m_pat[m_cause];
        else if (dnv) p = dnp;
        else if (m_have) p = m_dn;
        else p = m_pat[0];
        bitq.delete();
        for (int i = 3; i >= 0; i--) bitq.push_back((p >> i) & 1);
      end
      exp_bit = (bitq.size() > 0) ? bitq.pop_front() : 0;
      if (soc) begin
        m_active = 1; m_cnt = 0; m_vld = cvld; m_cause = cause; m_have = 0;
      end else if (m_active) begin
        if (ld) m_active = 0; else m_cnt++;
        if (dnv) begin m_have = 1; m_dn = dnp; end
      end
      if (we) m_pat[addr] = wd;
    end
  end

  always @(negedge clk) begin
    cyc++;
    total++;
    if (ack !== exp_bit[0]) begin
      bad++;
      $display("FAIL %s ack actual=%0b expected=%0b cycle=%0d", cur_req, ack, exp_bit[0], cyc);
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one slot: len cycles, dn strobe on edge dn_at (-1 none), write on edge wr_at
  task automatic slot(input bit v, input int c, input int dn_at, input int dn_val,
                      input int len, input int wr_at = -1, input int wa = 0,
                      input int wv = 0, input int dn2_at = -1, input int dn2_val = 0);
    for (int j = 0; j < len; j++) begin
      soc = (j == 0); cvld = (j == 0) ? v : 1'b0; cause = (j == 0) ? 2'(c) : 2'd0;
      dnv = (j == dn_at) || (j == dn2_at);
      dnp = (j == dn2_at) ? 4'(dn2_val) : 4'(dn_val);
      we = (j == wr_at); addr = 2'(wa); wd = 4'(wv);
      @(negedge clk);
    end
    soc = 0; dnv = 0; we = 0;
  endtask

  task automatic write(input int a, input int v);
    we = 1; addr = 2'(a); wd = 4'(v);
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; repeat (3) @(negedge clk);
    // R1 defaults seen through causes; R4 cause selection
    cur_req = "R4"; slot(1, 1, -1, 0, 12); slot(1, 2, -1, 0, 12); slot(1, 3, -1, 0, 12);
    cur_req = "R7"; slot(0, 2, 3, 5, 11);
    // R2 reprogram
    cur_req = "R2"; write(0, 4'b0110); write(1, 4'b0011); write(2, 4'b1111); write(3, 4'b0101);
    slot(0, 0, -1, 0, 12); slot(1, 1, -1, 0, 12); slot(1, 2, -1, 0, 13); slot(1, 3, -1, 0, 10);
    cur_req = "R2"; slot(1, 1, -1, 0, 12, OFS, 1, 4'b1000);
    slot(1, 1, -1, 0, 12, OFS - 1, 1, 4'b1110);
    // R6 relay
    cur_req = "R6"; slot(1, 0, 2, 4'b1011, 12); slot(1, 0, OFS, 4'b1101, 12);
    slot(1, 0, 1, 4'b0001, 12, -1, 0, 0, 4, 4'b1001);
    // R5 local overrides
    cur_req = "R5"; slot(1, 3, 2, 4'b1011, 12); slot(1, 1, OFS, 4'b0111, 12);
    cur_req = "R8"; slot(1, 0, -1, 0, 12);
    // R9 ignored strobes
    cur_req = "R9"; slot(1, 0, 0, 4'b1111, 12); slot(1, 0, OFS + 1, 4'b1111, 12);
    // R10 restart
    cur_req = "R10"; slot(1, 1, -1, 0, 3); slot(1, 0, 2, 4'b1010, 12);
    cur_req = "R3"; slot(0, 0, -1, 0, 10); slot(1, 0, 3, 4'b1000, 10); slot(1, 0, 3, 4'b0001, 14);
    // R1 reset again
    cur_req = "R1"; rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    slot(0, 0, -1, 0, 12); slot(1, 1, -1, 0, 12);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule